// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Condition Flags

This block is a purely combinational arithmetic logic unit of parameterizable width. It is built from identical one-bit slices. Each slice holds an AND gate, an OR gate and a full adder, and it can invert either operand bit before that logic. Carries ripple from the lowest slice to the highest. A 4-bit control word sets the operation. Its top bit inverts operand A. The next bit inverts operand B and also feeds the carry into the lowest slice. The low two bits choose the slice output: 0 gives AND, 1 gives OR and 2 gives the adder sum.

With this split, subtraction is an add of A and the inverted B with a carry-in of one. NOR is an AND of the two inverted operands. Neither needs a function unit of its own.

Beside the result word, the block drives four condition flags: zero, sign, carry and signed overflow. During a subtraction it also drives a signed less-than output and an equality output. It suits the execute stage of a simple datapath, where the flags go to a condition register held elsewhere.

Top module: `bitslice_alu`

## Requirements
- R1: Control code 4'b0000 gives the bitwise AND of A and B. Control code 4'b0001 gives the bitwise OR.
- R2: Control code 4'b0010 gives A plus B modulo 2^W. The carry flag is the carry out of the top slice.
- R3: Control code 4'b0110 gives A minus B modulo 2^W. The carry flag is the carry out of the top slice, which is 1 exactly when A is greater than or equal to B as unsigned numbers.
- R4: Control code 4'b1100 gives the bitwise NOR of A and B.
- R5: For the five defined codes, the zero flag is 1 exactly when every result bit is 0.
- R6: For the five defined codes, the sign flag equals result bit W-1.
- R7: The overflow flag is 1 when the two's-complement add or subtract result cannot be represented in W bits. It is 0 for the three logic codes.
- R8: The carry flag is 0 for the logic codes 0000, 0001 and 1100.
- R9: Any other control code drives the result to zero and clears all four flags and both compare outputs.
- R10: With code 0110, less_than is 1 exactly when A is less than B as signed numbers, and equal is 1 exactly when A equals B. With any other code, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | Operand A |
| opnd_b | input | W | Operand B |
| ctrl | input | 4 | Control word: [3] invert A, [2] invert B and carry-in, [1:0] slice select |
| result | output | W | Result word |
| flag_zero | output | 1 | Result is all zero |
| flag_sign | output | 1 | Top bit of the result |
| flag_carry | output | 1 | Carry out of the top slice (add and subtract only) |
| flag_ovf | output | 1 | Signed overflow (add and subtract only) |
| less_than | output | 1 | Signed A < B, valid for subtract |
| equal | output | 1 | A == B, valid for subtract |

## Verification
The bench drives the most negative value against itself, against one and against all ones. On this operand set, an overflow flag taken from the wrong carry pair, or a less-than output that ignores overflow, gives the wrong answer. Equal operands and subtracting from zero show whether the carry-in of one reaches slice 0. A design without it would be off by one and would show a borrow as the inverse carry. Logic operations are run on operands that would carry or overflow if added, so that a carry or overflow flag which leaks into AND, OR or NOR is seen. Every control code outside the five defined ones is applied with nonzero operands, which catches a decode that lets the slice output pass through.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   ctrl,
  output logic [W-1:0] result,
  output logic         flag_zero,
  output logic         flag_sign,
  output logic         flag_carry,
  output logic         flag_ovf,
  output logic         less_than,
  output logic         equal
);
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_NOR = 4'b1100;

  logic         inv_a, inv_b;
  logic [1:0]   sel;
  logic [W:0]   cy;
  logic [W-1:0] slice_out;
  logic         known, arith, is_sub;

  assign inv_a = ctrl[3];
  assign inv_b = ctrl[2];
  assign sel   = ctrl[1:0];
  assign cy[0] = inv_b;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic ai, bi, s_and, s_or, s_sum;
    assign ai    = opnd_a[i] ^ inv_a;
    assign bi    = opnd_b[i] ^ inv_b;
    assign s_and = ai & bi;
    assign s_or  = ai | bi;
    assign s_sum = ai ^ bi ^ cy[i];
    assign cy[i+1] = (ai & bi) | (cy[i] & (ai ^ bi));
    always_comb begin
      case (sel)
        2'd0:    slice_out[i] = s_and;
        2'd1:    slice_out[i] = s_or;
        2'd2:    slice_out[i] = s_sum;
        default: slice_out[i] = 1'b0;
      endcase
    end
  end

  assign known  = (ctrl == OP_AND) || (ctrl == OP_OR) || (ctrl == OP_ADD) ||
                  (ctrl == OP_SUB) || (ctrl == OP_NOR);
  assign arith  = (ctrl == OP_ADD) || (ctrl == OP_SUB);
  assign is_sub = (ctrl == OP_SUB);

  assign result     = known ? slice_out : '0;
  assign flag_zero  = known && (slice_out == '0);
  assign flag_sign  = known && slice_out[W-1];
  assign flag_carry = arith && cy[W];
  assign flag_ovf   = arith && (cy[W] ^ cy[W-1]);
  assign less_than  = is_sub && (slice_out[W-1] ^ cy[W] ^ cy[W-1]);
  assign equal      = is_sub && (slice_out == '0);

  always_comb begin
    if (!known)
      AST_UNDEF_QUIET: assert (result == '0 && !flag_zero && !flag_sign && !flag_carry && !flag_ovf && !less_than && !equal); // R9
    if (known && !arith)
      AST_LOGIC_NO_CARRY: assert (!flag_carry && !flag_ovf); // R8
    if (ctrl == OP_ADD)
      AST_ADD_SUM: assert ({flag_carry, result} == {1'b0, opnd_a} + {1'b0, opnd_b}); // R2
    if (is_sub)
      AST_SUB_BORROW: assert (flag_carry == (opnd_a >= opnd_b)); // R3
    if (is_sub)
      AST_SUB_EQUAL: assert (equal == (opnd_a == opnd_b)); // R10
    if (arith)
      AST_NO_OVERFLOW: assert (!flag_ovf || (opnd_a[W-1] ^ ctrl[2]) == opnd_b[W-1] ^ ctrl[2] ^ (ctrl == OP_SUB)); // R7
    AST_ZERO_SIGN: assert (!(flag_zero && flag_sign)); // R5
  end
endmodule

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;
  localparam int W = 32;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   ctrl;
  logic z, s, c, v, lt, eq;
  int checks = 0, errors = 0;
  bit done = 0;

  bitslice_alu #(.W(W)) i_bitslice_alu (
    .opnd_a(a), .opnd_b(b), .ctrl(ctrl), .result(res),
    .flag_zero(z), .flag_sign(s), .flag_carry(c), .flag_ovf(v),
    .less_than(lt), .equal(eq)
  );

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ctrl=%b a=%h b=%h got=%h exp=%h", tag, ctrl, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic [3:0] tc, input string tag);
    logic [W-1:0] er;
    logic ec, ev, elt, eeq, known;
    logic [W:0] wide;
    @(negedge clk);
    a = ta; b = tb_; ctrl = tc;
    er = '0; ec = 0; ev = 0; elt = 0; eeq = 0; known = 1;
    case (tc)
      4'b0000: er = ta & tb_;
      4'b0001: er = ta | tb_;
      4'b0010: begin
        wide = {1'b0, ta} + {1'b0, tb_}; er = wide[W-1:0]; ec = wide[W];
        ev = (ta[W-1] == tb_[W-1]) && (er[W-1] != ta[W-1]);
      end
      4'b0110: begin
        er = ta - tb_; ec = (ta >= tb_);
        ev = (ta[W-1] != tb_[W-1]) && (er[W-1] != ta[W-1]);
        elt = ($signed(ta) < $signed(tb_)); eeq = (ta == tb_);
      end
      4'b1100: er = ~(ta | tb_);
      default: known = 0;
    endcase
    @(posedge clk); #5;
    chk(res, er, tag);
    chk(W'(z), W'(known && er == '0), "R5 zero");
    chk(W'(s), W'(known && er[W-1]), "R6 sign");
    chk(W'(v), W'(ev), "R7 overflow");
    chk(W'(c), W'(ec), (tc == 4'b0010 || tc == 4'b0110) ? tag : "R8 carry");
    chk(W'(lt), W'(elt), "R10 less_than");
    chk(W'(eq), W'(eeq), "R10 equal");
  endtask

  task automatic t_logic;
    apply(32'hF0F0_1234, 32'hFF00_5678, 4'b0000, "R1 and");
    apply(32'hF0F0_1234, 32'hFF00_5678, 4'b0001, "R1 or");
    apply(ONES, ONES, 4'b0000, "R1 and ones");
    apply(MINV, MINV, 4'b0001, "R1 or minv");
    apply(32'h0, 32'h0, 4'b0001, "R1 or zero");
  endtask

  task automatic t_add;
    apply(32'd5, 32'd7, 4'b0010, "R2 add");
    apply(ONES, 32'd1, 4'b0010, "R2 add wrap");
    apply(MINV, MINV, 4'b0010, "R2 add minv");
    apply(32'h7FFF_FFFF, 32'd1, 4'b0010, "R2 add ovf");
    apply(ONES, ONES, 4'b0010, "R2 add ones");
  endtask

  task automatic t_sub;
    apply(32'd9, 32'd9, 4'b0110, "R3 sub equal");
    apply(32'd0, 32'd1, 4'b0110, "R3 sub borrow");
    apply(MINV, 32'd1, 4'b0110, "R3 sub minv");
    apply(32'd1, MINV, 4'b0110, "R3 sub minus minv");
    apply(MINV, ONES, 4'b0110, "R3 sub minv ones");
    apply(ONES, MINV, 4'b0110, "R3 sub ones minv");
    apply(MINV, MINV, 4'b0110, "R3 sub minv self");
  endtask

  task automatic t_nor;
    apply(32'h0, 32'h0, 4'b1100, "R4 nor zero");
    apply(ONES, 32'h0, 4'b1100, "R4 nor ones");
    apply(32'hA5A5_0000, 32'h0000_5A5A, 4'b1100, "R4 nor mix");
  endtask

  task automatic t_undef;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] cc;
      cc = 4'(k);
      if (cc != 4'b0000 && cc != 4'b0001 && cc != 4'b0010 && cc != 4'b0110 && cc != 4'b1100)
        apply(ONES, 32'h1234_5678, cc, "R9 undefined");
    end
  endtask

  task automatic t_random;
    logic [3:0] codes [5] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b1100};
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom(); rb = (k % 7 == 0) ? ra : $urandom();
      apply(ra, rb, codes[k % 5], "R1-R10 random");
    end
  endtask

  initial begin
    a = '0; b = '0; ctrl = 4'b0000;
    @(posedge clk); #5;
    chk(res, '0, "R1 initial and");
    chk(W'(z), W'(1), "R5 initial zero");
    t_logic; t_add; t_sub; t_nor; t_undef; t_random;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule